// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and a carry-in, and returns a sum of the same width plus a carry-out. It is purely combinational: there is no clock, no reset and no internal state. The result appears at the outputs once the inputs have settled.

The operand width is split into equal slices. The lowest slice is a single ripple chain fed by the external carry-in, and its sum bits are final. Every higher slice holds two ripple chains that work in parallel. One assumes that no carry enters the slice and the other assumes that one does. The selected carry leaving the slice below then steers a multiplexer that picks the matching sum bits and slice carry. The worst-case path is therefore one slice of ripple followed by a chain of multiplexers, and not a ripple across the full width.

Both the total width and the slice size are parameters. The width must be a whole multiple of the slice size, and any other combination stops elaboration. When the two are equal, the block builds one plain ripple chain with no duplicated copies.

Top module: `csel_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals a + b + cin, treated as unsigned numbers in which bit i of a, b and sum carries weight 2^i and cout carries weight 2^WIDTH.
- R2: The lowest GROUP bits of sum equal the low GROUP bits of a[GROUP-1:0] + b[GROUP-1:0] + cin, whatever the upper operand bits hold.
- R3: A carry produced in one slice reaches every slice above it. With a and b both holding all ones the result is sum all ones and cout 1 when cin is 1. With a all ones, b zero and cin 1 the result is sum zero and cout 1.
- R4: Alternating operands work in both phases. With a = 1010...10 and b = 0101...01, the result is sum all ones and cout 0 when cin is 0, and sum zero and cout 1 when cin is 1.
- R5: With a and b zero, sum[0] equals cin, every other sum bit is 0, and cout is 0.
- R6: A build with WIDTH equal to GROUP gives results identical to R1 through a single ripple chain.
- R7: Builds with several slices, for example WIDTH 32 with GROUP 4 or 8, meet R1 for random operands and for the patterns named in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds four copies of the adder. The first uses WIDTH 8 with GROUP 4 and the second uses WIDTH 8 with GROUP 8, and both are driven with all 131072 combinations of a, b and cin. This covers every carry pattern across the single slice boundary, and it also compares the speculative structure against the degenerate ripple-only build. The other two copies use WIDTH 32 with GROUP 4 and with GROUP 8. They see a table of long-carry and alternating patterns and a few thousand pseudo-random operands, which exercises chains of seven and of three select stages.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Number of slices a width splits into.
  function automatic int slice_count(input int width, input int group);
    return width / group;
  endfunction
endpackage

// File: rtl/csel_fa.sv
module csel_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_bit
    csel_fa u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end

  assign co = chain[N];

  // R1 R2: the bitwise chain agrees with arithmetic addition
  always_comb begin
    ripple_sum_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y} + (N+1)'(ci)))
      else $error("ripple slice result wrong");
  end
endmodule

// File: rtl/csel_spec_slice.sv
module csel_spec_slice #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         sel,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N-1:0] s_lo, s_hi;
  logic         c_lo, c_hi;

  csel_ripple #(.N(N)) u_assume0 (
    .x(x), .y(y), .ci(1'b0), .s(s_lo), .co(c_lo)
  );
  csel_ripple #(.N(N)) u_assume1 (
    .x(x), .y(y), .ci(1'b1), .s(s_hi), .co(c_hi)
  );

  always_comb begin
    s  = sel ? s_hi : s_lo;
    co = sel ? c_hi : c_lo;
  end

  // R3: a slice that carries out without an incoming carry also carries out with one
  always_comb begin
    spec_carry_order_chk: assert (!c_lo || c_hi)
      else $error("speculative carries out of order");
  end

  // R3: the two speculative copies differ by exactly one
  always_comb begin
    spec_step_chk: assert ({c_hi, s_hi} == {c_lo, s_lo} + (N+1)'(1))
      else $error("speculative copies disagree");
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 8,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csel_pkg::*;

  localparam int NSLICE = slice_count(WIDTH, GROUP);

  if ((WIDTH % GROUP) != 0 || GROUP < 1) begin : g_bad_cfg
    $error("csel_adder: WIDTH must be a multiple of GROUP");
  end

  logic [NSLICE:0] link;
  assign link[0] = cin;

  if (NSLICE == 1) begin : g_flat
    // R6: single ripple chain, no speculative copies
    csel_ripple #(.N(WIDTH)) u_only (
      .x(a), .y(b), .ci(cin), .s(sum), .co(link[1])
    );
  end else begin : g_split
    // R2: lowest slice driven by the external carry
    csel_ripple #(.N(GROUP)) u_base (
      .x (a[GROUP-1:0]),
      .y (b[GROUP-1:0]),
      .ci(cin),
      .s (sum[GROUP-1:0]),
      .co(link[1])
    );
    for (genvar k = 1; k < NSLICE; k++) begin : g_upper
      csel_spec_slice #(.N(GROUP)) u_slice (
        .x  (a[k*GROUP +: GROUP]),
        .y  (b[k*GROUP +: GROUP]),
        .sel(link[k]),
        .s  (sum[k*GROUP +: GROUP]),
        .co (link[k+1])
      );
    end
  end

  assign cout = link[NSLICE];

  // R1
  always_comb begin
    total_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
      else $error("adder total wrong");
  end
endmodule

// File: tb/test_csel_adder.sv
module test_csel_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  a8, b8;
  logic        c8;
  logic [7:0]  s8, s8f;
  logic        co8, co8f;
  logic [31:0] a32, b32;
  logic        c32;
  logic [31:0] s32a, s32b;
  logic        co32a, co32b;

  csel_adder #(.WIDTH(8), .GROUP(4)) i_csel_adder (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
  csel_adder #(.WIDTH(8), .GROUP(8)) i_csel_adder_flat (
    .a(a8), .b(b8), .cin(c8), .sum(s8f), .cout(co8f));
  csel_adder #(.WIDTH(32), .GROUP(4)) i_csel_adder_w32g4 (
    .a(a32), .b(b32), .cin(c32), .sum(s32a), .cout(co32a));
  csel_adder #(.WIDTH(32), .GROUP(8)) i_csel_adder_w32g8 (
    .a(a32), .b(b32), .cin(c32), .sum(s32b), .cout(co32b));

  // {a, b} operand pairs; cin alternates with the row index
  localparam logic [63:0] TAB [10] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'hAAAA_AAAA, 32'h5555_5555},
    {32'h5555_5555, 32'hAAAA_AAAA},
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0000},
    {32'h0FFF_FFFF, 32'h0000_0001},
    {32'h8000_0000, 32'h8000_0000},
    {32'h1234_5678, 32'hEDCB_A987},
    {32'hF0F0_F0F0, 32'h0F0F_0F10}
  };

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run32(input logic [31:0] x, input logic [31:0] y, input logic c, input string req);
    logic [32:0] exp;
    @(posedge clk);
    a32 = x; b32 = y; c32 = c;
    @(negedge clk);
    exp = {1'b0, x} + {1'b0, y} + 33'(c);
    check({req, " R7 g4"}, {co32a, s32a}, exp);
    check({req, " R7 g8"}, {co32b, s32b}, exp);
  endtask

  initial begin
    logic [31:0] seed;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    repeat (2) @(posedge clk);

    // R5 zero operands
    @(posedge clk); a8 = 8'h00; b8 = 8'h00; c8 = 1'b1;
    @(negedge clk);
    check("R5 zero cin1", {24'd0, co8, s8}, 33'h001);
    @(posedge clk); c8 = 1'b0;
    @(negedge clk);
    check("R5 zero cin0", {24'd0, co8, s8}, 33'h000);

    // R3 carry through all slices at 8 bits
    @(posedge clk); a8 = 8'hFF; b8 = 8'hFF; c8 = 1'b1;
    @(negedge clk);
    check("R3 ones+ones+1", {24'd0, co8, s8}, 33'h1FF);
    @(posedge clk); a8 = 8'hFF; b8 = 8'h00; c8 = 1'b1;
    @(negedge clk);
    check("R3 ones+0+1", {24'd0, co8, s8}, 33'h100);

    // R4 alternating patterns
    @(posedge clk); a8 = 8'hAA; b8 = 8'h55; c8 = 1'b0;
    @(negedge clk);
    check("R4 alt cin0", {24'd0, co8, s8}, 33'h0FF);
    @(posedge clk); c8 = 1'b1;
    @(negedge clk);
    check("R4 alt cin1", {24'd0, co8, s8}, 33'h100);

    // R2 low slice independent of upper bits
    @(posedge clk); a8 = 8'hF9; b8 = 8'h36; c8 = 1'b1;
    @(negedge clk);
    check("R2 low slice", {29'd0, s8[3:0]}, 33'h0);
    @(posedge clk); a8 = 8'h09; b8 = 8'hC6; c8 = 1'b1;
    @(negedge clk);
    check("R2 low slice upper changed", {29'd0, s8[3:0]}, 33'h0);

    // R1 and R6 exhaustive at 8 bits
    for (int v = 0; v < 131072; v++) begin
      logic [8:0] exp8;
      @(posedge clk);
      a8 = v[16:9]; b8 = v[8:1]; c8 = v[0];
      @(negedge clk);
      exp8 = {1'b0, v[16:9]} + {1'b0, v[8:1]} + 9'(v[0]);
      check("R1 exhaustive", {24'd0, co8, s8}, {24'd0, exp8});
      check("R6 flat", {24'd0, co8f, s8f}, {24'd0, exp8});
    end

    // R3 R4 R5 R7 table at 32 bits
    for (int i = 0; i < 10; i++) begin
      run32(TAB[i][63:32], TAB[i][31:0], i[0] ? 1'b0 : 1'b1, "R3 R4 R5 table");
    end
    @(negedge clk);
    a32 = 32'hFFFF_FFFF; b32 = 32'hFFFF_FFFF; c32 = 1'b1;
    @(negedge clk);
    check("R3 w32 all ones", {co32a, s32a}, 33'h1_FFFF_FFFF);
    a32 = 32'hAAAA_AAAA; b32 = 32'h5555_5555; c32 = 1'b1;
    @(negedge clk);
    check("R4 w32 alt", {co32b, s32b}, 33'h1_0000_0000);

    // R7 random operands
    seed = 32'h1ACE_2B3D;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      x = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      y = seed;
      run32(x, y, seed[7], "R1 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule